// File: doc/BRIEF.md
# Four-Word Page Read Burst Engine

This block reads short bursts from an asynchronous pseudo-static RAM that supports fast reads within an aligned page of four 16-bit words. A request gives a start word address and a burst length. The engine drives chip enable low and presents the full address. It waits the full random-access latency for the first word. For each later word it steps only the two low address bits and waits the shorter in-page latency. Each word is captured into a registered output stream with a valid strobe, a last-word marker and a truncation flag.

A burst never leaves its page. If the requested length would carry the low address bits past the page end, the engine stops at the last word of the page and raises the truncation flag together with the last word. After the last word it releases chip enable and output enable and stays busy for a short float interval. The memory relies on idle time for its internal refresh. A timer therefore watches for stretches of continuous activity and, before a safe window runs out, holds the engine in a standby gap with chip enable high.

The controller has five states. `ST_IDLE` goes to `ST_FIRST` when a start is accepted, or to `ST_GUARD` when a standby gap is due. `ST_FIRST` waits out the first-word latency. From there it goes to `ST_PAGE` if more words remain, or to `ST_REL` after the final word. `ST_PAGE` repeats for each in-page word and goes to `ST_REL` after the final word. `ST_REL` returns to `ST_IDLE` once the float interval has elapsed. `ST_GUARD` returns to `ST_IDLE` once the standby gap has cleared the refresh window.

Top module: `psram_page_burst`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `rd_valid` is low and `busy` is low.
- R2: A start is accepted only while `busy` is low. On the accepting edge `mem_addr` takes `start_addr`, and the first word is captured into `rd_data` on the edge FIRST_CYC (7) cycles later.
- R3: `mem_ce_n` falls on the accepting edge and `mem_oe_n` falls OE_LAG (3) cycles later. `mem_oe_n` is never low while `mem_ce_n` is high.
- R4: Each later word is captured PAGE_CYC (3) cycles after the previous one. Between captures only `mem_addr[1:0]` changes, and it increases by one per word.
- R5: While `mem_ce_n` is low, `mem_addr[19:2]` does not change. `mem_we_n` is high at all times.
- R6: `burst_len` codes 0, 1, 2 and 3 request 1, 2, 3 and 4 words. `rd_valid` pulses once per word, and `rd_last` is high with the final word only.
- R7: If `start_addr[1:0] + burst_len` exceeds 3, only `4 - start_addr[1:0]` words are read, and `rd_trunc` is high together with `rd_last`. Otherwise `rd_trunc` stays low.
- R8: `mem_ce_n` and `mem_oe_n` rise on the edge that captures the final word. `busy` stays high for HZ_CYC (3) further cycles.
- R9: A start pulse while `busy` is high has no effect. The current burst continues unchanged, and no further burst follows it.
- R10: `mem_ce_n` is never kept from a run of GUARD_CYC (7) consecutive high cycles for WIN_CYC (400) cycles or more. Under back-to-back requests the engine inserts such a standby gap itself, with `busy` held high.
- R11: Each captured word equals `mem_rdata` as presented for the address driven at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a burst (taken when busy is low) |
| start_addr | input | 20 | Word address of the first word |
| burst_len | input | 2 | Number of words minus one |
| busy | output | 1 | Engine cannot accept a start |
| rd_valid | output | 1 | rd_data holds a new word |
| rd_data | output | 16 | Captured read word |
| rd_last | output | 1 | Final word of the burst |
| rd_trunc | output | 1 | Burst was cut at the page end (with rd_last) |
| mem_addr | output | 20 | Memory word address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held high |
| mem_rdata | input | 16 | Memory read data |

## Verification
Embedded assertions check several properties on every cycle: the upper address bits stay fixed while chip enable is low, output enable never runs ahead of chip enable, and chip enable rises only with a last word. They also check that truncation and last flags come with a valid word, that consecutive words are never adjacent, that a start during busy does not move the address, and that the refresh window counter stays in range. Other behaviours need the bench's scenarios. These are the exact capture cycles against a memory model that returns garbage when sampled too early, the word count and truncation for each alignment and length, the data values, the float interval, and the automatic standby gap under continuous requests.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_PAGE,
        ST_REL,
        ST_GUARD
    } burst_state_t;
endpackage

// File: rtl/psram_page_plan.sv
// Works out how many words remain after the first one and whether the
// request has to be cut at the page end.
module psram_page_plan #(
    parameter int PAGE_BITS = 2
) (
    input  logic [PAGE_BITS-1:0] lo_addr,
    input  logic [PAGE_BITS-1:0] len_m1,
    output logic [PAGE_BITS-1:0] rem_words,
    output logic                 cut
);
    logic [PAGE_BITS:0] end_pos;

    always_comb begin
        end_pos   = {1'b0, lo_addr} + {1'b0, len_m1};
        cut       = end_pos[PAGE_BITS];
        rem_words = cut ? ~lo_addr : len_m1;
    end
endmodule

// File: rtl/psram_refresh_guard.sv
// Tracks how long the memory has gone without a standby run long enough
// for its internal refresh and requests a gap before the window closes.
module psram_refresh_guard #(
    parameter int WIN_CYC   = 400,
    parameter int GUARD_CYC = 7,
    parameter int GUARD_AT  = 370
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic due
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int SB_W  = $clog2(GUARD_CYC + 1);
    localparam logic [SB_W-1:0]  SB_FULL = SB_W'(GUARD_CYC);
    localparam logic [SB_W-1:0]  SB_DONE = SB_W'(GUARD_CYC - 1);
    localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(WIN_CYC);
    localparam logic [WIN_W-1:0] DUE_AT  = WIN_W'(GUARD_AT);

    logic [SB_W-1:0]  stby_cnt;
    logic [WIN_W-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_cnt <= '0;
            win_cnt  <= '0;
        end else begin
            if (!ce_n)
                stby_cnt <= '0;
            else if (stby_cnt != SB_FULL)
                stby_cnt <= stby_cnt + SB_W'(1);

            if (ce_n && stby_cnt >= SB_DONE)
                win_cnt <= '0;
            else if (win_cnt != WIN_MAX)
                win_cnt <= win_cnt + WIN_W'(1);
        end
    end

    assign due = (win_cnt >= DUE_AT);

    // R10: the refresh window never runs out
    p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt < WIN_MAX);
endmodule

// File: rtl/psram_burst_fsm.sv
module psram_burst_fsm
    import psram_burst_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 2,
    parameter int FIRST_CYC = 7,
    parameter int PAGE_CYC  = 3,
    parameter int OE_LAG    = 3,
    parameter int HZ_CYC    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [PAGE_BITS-1:0] rem_in,
    input  logic                 cut_in,
    input  logic                 guard_due,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 ce_n,
    output logic                 oe_n,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 rd_last,
    output logic                 rd_trunc,
    output logic                 busy
);
    localparam int MAX_FP = (FIRST_CYC > PAGE_CYC) ? FIRST_CYC : PAGE_CYC;
    localparam int MAX_C  = (MAX_FP > HZ_CYC) ? MAX_FP : HZ_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] C_PAGE  = CNT_W'(PAGE_CYC - 1);
    localparam logic [CNT_W-1:0] C_HZ    = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] C_OE    = CNT_W'(FIRST_CYC - OE_LAG);

    burst_state_t state, state_nx;
    logic [CNT_W-1:0]     cnt;
    logic [PAGE_BITS-1:0] rem;
    logic                 cut_q;
    logic                 accept;
    logic                 capture;

    assign accept  = (state == ST_IDLE) && start && !guard_due;
    assign capture = ((state == ST_FIRST) || (state == ST_PAGE)) && (cnt == '0);
    assign busy    = (state != ST_IDLE) || guard_due;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (guard_due)  state_nx = ST_GUARD;
                else if (start) state_nx = ST_FIRST;
            end
            ST_FIRST, ST_PAGE: begin
                if (cnt == '0) state_nx = (rem == '0) ? ST_REL : ST_PAGE;
            end
            ST_REL: begin
                if (cnt == '0) state_nx = ST_IDLE;
            end
            ST_GUARD: begin
                if (!guard_due) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_trunc <= 1'b0;
            cnt      <= '0;
            rem      <= '0;
            cut_q    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_trunc <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mem_addr <= start_addr;
                        ce_n     <= 1'b0;
                        cnt      <= C_FIRST;
                        rem      <= rem_in;
                        cut_q    <= cut_in;
                    end
                end
                ST_FIRST, ST_PAGE: begin
                    if (state == ST_FIRST && cnt == C_OE)
                        oe_n <= 1'b0;
                    if (capture) begin
                        rd_valid <= 1'b1;
                        rd_data  <= mem_rdata;
                        if (rem == '0) begin
                            rd_last  <= 1'b1;
                            rd_trunc <= cut_q;
                            ce_n     <= 1'b1;
                            oe_n     <= 1'b1;
                            cnt      <= C_HZ;
                        end else begin
                            mem_addr[PAGE_BITS-1:0] <= mem_addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
                            rem <= rem - PAGE_BITS'(1);
                            cnt <= C_PAGE;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_REL: begin
                    if (cnt != '0) cnt <= cnt - CNT_W'(1);
                end
                ST_GUARD: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R5: page held while the chip is selected
    p_upper_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !$past(ce_n)) |-> $stable(mem_addr[ADDR_W-1:PAGE_BITS]));
    // R3: output enable only inside chip enable
    p_oe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ce_n);
    // R6: last marker only with a word
    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
    // R7: truncation only reported with the last word
    p_trunc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_trunc |-> rd_last);
    // R8: chip enable released only with the last word
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> rd_last);
    // R9: a start during busy does not move the page address
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mem_addr[ADDR_W-1:PAGE_BITS]));

    generate
        if (PAGE_CYC > 1) begin : g_gap
            // R4: words never come on adjacent cycles
            p_page_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                rd_valid |=> !rd_valid);
        end
    endgenerate
endmodule

// File: rtl/psram_page_burst.sv
module psram_page_burst #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 2,
    parameter int FIRST_CYC = 7,
    parameter int PAGE_CYC  = 3,
    parameter int OE_LAG    = 3,
    parameter int HZ_CYC    = 3,
    parameter int WIN_CYC   = 400,
    parameter int GUARD_CYC = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [PAGE_BITS-1:0] burst_len,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_last,
    output logic                 rd_trunc,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    input  logic [DATA_W-1:0]    mem_rdata
);
    localparam int PAGE_WORDS = 1 << PAGE_BITS;
    localparam int BURST_MAX  = FIRST_CYC + (PAGE_WORDS - 1) * PAGE_CYC;
    localparam int GUARD_AT   = WIN_CYC - BURST_MAX - HZ_CYC - GUARD_CYC - 4;

    logic [PAGE_BITS-1:0] rem_words;
    logic                 cut;
    logic                 guard_due;

    assign mem_we_n = 1'b1;

    psram_page_plan #(.PAGE_BITS(PAGE_BITS)) u_plan (
        .lo_addr   (start_addr[PAGE_BITS-1:0]),
        .len_m1    (burst_len),
        .rem_words (rem_words),
        .cut       (cut)
    );

    psram_refresh_guard #(
        .WIN_CYC   (WIN_CYC),
        .GUARD_CYC (GUARD_CYC),
        .GUARD_AT  (GUARD_AT)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (mem_ce_n),
        .due   (guard_due)
    );

    psram_burst_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_BITS (PAGE_BITS),
        .FIRST_CYC (FIRST_CYC),
        .PAGE_CYC  (PAGE_CYC),
        .OE_LAG    (OE_LAG),
        .HZ_CYC    (HZ_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .rem_in     (rem_words),
        .cut_in     (cut),
        .guard_due  (guard_due),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .rd_trunc   (rd_trunc),
        .busy       (busy)
    );
endmodule

// File: tb/psram_page_burst_test.sv
`timescale 1ns/1ps
module psram_page_burst_test;
    localparam int FIRST  = 7;
    localparam int PAGE   = 3;
    localparam int OELAG  = 3;
    localparam int OE_ACC = 4;
    localparam int HZ     = 3;
    localparam int WIN    = 400;
    localparam int GUARD  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] start_addr = '0;
    logic [1:0]  burst_len = '0;
    logic        busy, rd_valid, rd_last, rd_trunc;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [15:0] mem_rdata = 16'hDEAD;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    psram_page_burst uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .burst_len(burst_len), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .rd_trunc(rd_trunc),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] pat(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], 8'h3C};
    endfunction

    // memory model: data only valid once every latency has elapsed
    logic [19:0] prev_addr = '0;
    logic        prev_ce_n = 1'b1, prev_oe_n = 1'b1;
    int full_age = 0, page_age = 0, oe_age = 0;
    always @(negedge clk) begin
        if (mem_ce_n) begin
            full_age = 0; page_age = 0;
        end else begin
            if (prev_ce_n || mem_addr[19:2] != prev_addr[19:2]) full_age = 0; else full_age++;
            if (prev_ce_n || mem_addr[1:0] != prev_addr[1:0]) page_age = 0; else page_age++;
        end
        if (mem_oe_n || prev_oe_n) oe_age = 0; else oe_age++;
        prev_addr = mem_addr; prev_ce_n = mem_ce_n; prev_oe_n = mem_oe_n;
        mem_rdata = (!mem_ce_n && !mem_oe_n && full_age >= FIRST - 1 &&
                     page_age >= PAGE - 1 && oe_age >= OE_ACC - 1) ? pat(mem_addr) : 16'hDEAD;
    end

    // refresh window monitor
    bit mon_on = 0;
    int run = 0, win = 0, max_win = 0;
    bit gap_seen = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_ce_n) run++; else run = 0;
            if (run >= GUARD) begin win = 0; gap_seen = 1; end else win++;
            if (win > max_win) max_win = win;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_burst(input logic [19:0] a, input logic [1:0] len,
                             input int words, input bit cut, input bit poke);
        int klast;
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        klast = FIRST + (words - 1) * PAGE;
        start = 1'b1; start_addr = a; burst_len = len;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= klast + HZ; k++) begin
            int idx;
            bit expv;
            if (k > 0) @(negedge clk);
            if (poke && k == 4) begin start = 1'b1; start_addr = 20'hBBBB0; burst_len = 2'd3; end
            if (poke && k == 5) start = 1'b0;
            if (k == 0) chk(mem_addr == a, "R2 start address", mem_addr, a);
            chk(mem_ce_n == (k >= klast), "R3/R8 ce_n", mem_ce_n, k >= klast);
            chk(mem_oe_n == !(k >= OELAG && k < klast), "R3/R8 oe_n", mem_oe_n, !(k >= OELAG && k < klast));
            chk(mem_we_n == 1'b1, "R5 we_n", mem_we_n, 1);
            chk(busy == (k < klast + HZ), "R8 busy", busy, k < klast + HZ);
            idx  = (k < FIRST) ? 0 : (k - FIRST) / PAGE + 1;
            if (k < klast) begin
                chk(mem_addr[19:2] == a[19:2], "R5 upper address", mem_addr[19:2], a[19:2]);
                chk(mem_addr[1:0] == 2'(a[1:0] + idx), "R4 low address", mem_addr[1:0], 2'(a[1:0] + idx));
            end
            expv = (k >= FIRST) && ((k - FIRST) % PAGE == 0) && ((k - FIRST) / PAGE < words);
            chk(rd_valid == expv, "R2/R4/R6 rd_valid", rd_valid, expv);
            if (expv) begin
                int i;
                logic [19:0] wa;
                i  = (k - FIRST) / PAGE;
                wa = {a[19:2], 2'(a[1:0] + i)};
                chk(rd_data == pat(wa), "R11 rd_data", rd_data, pat(wa));
                chk(rd_last == (i == words - 1), "R6 rd_last", rd_last, i == words - 1);
                chk(rd_trunc == (cut && i == words - 1), "R7 rd_trunc", rd_trunc, cut && i == words - 1);
            end
        end
    endtask

    typedef struct packed {
        logic [19:0] a;
        logic [1:0]  len;
        logic [2:0]  words;
        logic        cut;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{20'h12340, 2'd3, 3'd4, 1'b0},
        '{20'h0ABC1, 2'd2, 3'd3, 1'b0},
        '{20'hFFFF2, 2'd1, 3'd2, 1'b0},
        '{20'h55553, 2'd0, 3'd1, 1'b0},
        '{20'h00002, 2'd3, 3'd2, 1'b1},
        '{20'h80001, 2'd3, 3'd3, 1'b1},
        '{20'h7A5E3, 2'd1, 3'd1, 1'b1},
        '{20'h3C3C0, 2'd0, 3'd1, 1'b0},
        '{20'h3C3C1, 2'd1, 3'd2, 1'b0}
    };

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n == 1'b1, "R1 ce_n in reset", mem_ce_n, 1);
        chk(mem_oe_n == 1'b1, "R1 oe_n in reset", mem_oe_n, 1);
        chk(mem_we_n == 1'b1, "R1 we_n in reset", mem_we_n, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_burst(VECS[v].a, VECS[v].len, int'(VECS[v].words), VECS[v].cut, 1'b0);

        // R9: start pulse during a burst is ignored
        run_burst(20'h24680, 2'd3, 4, 1'b0, 1'b1);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1, "R9 no extra burst ce_n", mem_ce_n, 1);
            chk(rd_valid == 1'b0, "R9 no extra word", rd_valid, 0);
        end

        // R10: back-to-back requests must still leave refresh gaps
        mon_on = 1;
        for (int b = 0; b < 50; b++) begin
            while (busy) @(negedge clk);
            start = 1'b1; start_addr = {18'(b * 7), 2'b00}; burst_len = 2'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_on = 0;
        chk(max_win < WIN, "R10 refresh window", max_win, WIN);
        chk(gap_seen == 1'b1, "R10 standby gap inserted", gap_seen, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule